// File: doc/BRIEF.md
# Return Stack and Interrupt Entry Sequencer

This block keeps an eight-deep return stack in a small byte-wide data RAM that sits outside it. The stack pointer is the low three bits of an 8-bit status word that the block owns. Calls and interrupt entries push a two-byte frame. A plain return pulls the frame back into the program counter. A return from interrupt also restores the upper flag nibble of the status word from the frame. The block drives the RAM port, loads a new program counter through a one-cycle load strobe, and reports the base address of the working register bank.

Two interrupt sources are latched in the block, an external request and a timer overflow. They are arbitrated only when the core signals an instruction boundary. Only one interrupt may be in service at a time. The external source has the higher priority, and each source has its own rule for clearing its latch. The RAM has a one-cycle registered read, so a pull takes four cycles and a push takes two.

Top module: `psw_stack_irq`

## Requirements
- R1: A push (call or interrupt entry) writes the frame low byte to RAM address 8+2·sp and then writes the high byte to 9+2·sp in the next cycle. sp is status bits [2:0] and wraps from 7 to 0 when it increments. The pc load strobe rises two cycles after the request.
- R2: The frame low byte holds PC[7:0]. The high byte holds PC[11:8] in bits [3:0] and status bits [7:4] in bits [7:4].
- R3: A pull reads the frame at slot (sp−1) mod 8 and reloads the 12-bit PC from it. It sets sp to that slot and forces status bit 3 to 1. The pc load strobe rises four cycles after the request.
- R4: A return from interrupt takes status bits [7:4] from the saved high byte. A plain return keeps the current status bits [7:4].
- R5: The bank base output is 24 when status bit 4 is 1 and 0 otherwise. It follows every status change, including a restoring pull.
- R6: While an interrupt is in service, no interrupt is accepted. A return from interrupt ends service. A plain return does not.
- R7: A latched external request wins when it is enabled. The block loads PC 0x003, clears that latch and gives a one-cycle acknowledge pulse. With the external source disabled, the timer is taken, and the external latch stays set.
- R8: Taking a timer overflow loads PC 0x007 and clears the overflow latch, so a later boundary takes nothing.
- R9: Interrupts are accepted only in a cycle with the boundary strobe. Pending requests cause no RAM write and no PC load without it.
- R10: After reset the status word, bank base, load strobe, RAM write enable, in-service flag and acknowledge are all zero.
- R11: A call pushes the pc input as the return address and loads the call target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary_i | input | 1 | Instruction boundary strobe, when interrupts may be taken |
| pc_i | input | 12 | Return address to save on a push |
| call_i | input | 1 | Call request |
| call_tgt_i | input | 12 | Call destination |
| ret_i | input | 1 | Plain return request |
| reti_i | input | 1 | Return-from-interrupt request |
| psw_we_i | input | 1 | Status word write strobe |
| psw_d_i | input | 8 | Status word write data |
| ext_req_i | input | 1 | External interrupt request pulse |
| ext_en_i | input | 1 | External interrupt enable |
| tmr_ovf_i | input | 1 | Timer overflow pulse |
| tmr_en_i | input | 1 | Timer interrupt enable |
| ram_rdata_i | input | 8 | RAM read data, one cycle after the address |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | 8 | RAM address |
| ram_wdata_o | output | 8 | RAM write data |
| psw_o | output | 8 | Status word |
| bank_base_o | output | 8 | Working register bank base address |
| pc_load_o | output | 1 | One-cycle strobe: load pc_o |
| pc_o | output | 12 | New program counter (target, vector or return address) |
| ext_ack_o | output | 1 | External interrupt acknowledge pulse |
| irq_active_o | output | 1 | Interrupt in service |
| busy_o | output | 1 | Push or pull sequence in progress |

## Verification
Eight calls with different flag nibbles fill every slot and wrap the pointer to zero. A design with a wrong slot stride or a missing wrap would overwrite or misplace frames. Pulls alternate between plain and restoring returns, so a design that restored the flags on the wrong kind, left bit 3 clear or failed to update the bank base would show a wrong status word. The interrupt sequence raises both sources at once, retries while in service, and returns once with the wrong kind of return. A design that nested interrupts, let a plain return end service, left the timer latch set, ignored the external enable or took interrupts without the boundary strobe would load a vector it should not load.

// File: rtl/psw_stack_pkg.sv
package psw_stack_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_HI,
    ST_POP_LO,
    ST_POP_HI,
    ST_POP_FIN
  } seq_state_t;
endpackage

// File: rtl/irq_gate.sv
module irq_gate (
  input  logic clk,
  input  logic rst,
  input  logic boundary_i,
  input  logic idle_i,
  input  logic ext_req_i,
  input  logic ext_en_i,
  input  logic tmr_ovf_i,
  input  logic tmr_en_i,
  input  logic exit_i,
  output logic take_ext_o,
  output logic take_tmr_o,
  output logic active_o,
  output logic ack_o
);
  logic ext_pend_q, tmr_pend_q, act_q, ack_q;
  logic eligible;

  assign eligible   = boundary_i && idle_i && !act_q;
  assign take_ext_o = eligible && ext_pend_q && ext_en_i;
  assign take_tmr_o = eligible && !(ext_pend_q && ext_en_i) && tmr_pend_q && tmr_en_i;
  assign active_o   = act_q;
  assign ack_o      = ack_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_pend_q <= 1'b0;
      tmr_pend_q <= 1'b0;
      act_q      <= 1'b0;
      ack_q      <= 1'b0;
    end else begin
      ack_q <= take_ext_o;
      if (ext_req_i) ext_pend_q <= 1'b1;
      else if (take_ext_o) ext_pend_q <= 1'b0;
      if (tmr_ovf_i) tmr_pend_q <= 1'b1;
      else if (take_tmr_o) tmr_pend_q <= 1'b0;
      if (take_ext_o || take_tmr_o) act_q <= 1'b1;
      else if (exit_i) act_q <= 1'b0;
    end
  end

  // R7
  ack_fresh_chk: assert property (@(posedge clk) disable iff (rst)
    ack_q |-> (act_q && !$past(act_q)));

  // R8
  tmr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    take_tmr_o |=> (!tmr_pend_q || $past(tmr_ovf_i)));

  // R6
  no_nest_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(act_q) && act_q) |-> !ack_q);
endmodule

// File: rtl/frame_seq.sv
module frame_seq
  import psw_stack_pkg::*;
#(
  parameter int PC_W       = 12,
  parameter int DW         = 8,
  parameter int AW         = 8,
  parameter int SP_W       = 3,
  parameter int STACK_BASE = 8,
  parameter int BANK_BASE  = 24,
  parameter int EXT_VEC    = 3,
  parameter int TMR_VEC    = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take_ext_i,
  input  logic            take_tmr_i,
  input  logic            call_i,
  input  logic            ret_i,
  input  logic            reti_i,
  input  logic            psw_we_i,
  input  logic [DW-1:0]   psw_d_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic [PC_W-1:0] call_tgt_i,
  input  logic [DW-1:0]   ram_rdata_i,
  output logic            ram_we_o,
  output logic [AW-1:0]   ram_addr_o,
  output logic [DW-1:0]   ram_wdata_o,
  output logic [DW-1:0]   psw_o,
  output logic [AW-1:0]   bank_base_o,
  output logic            pc_load_o,
  output logic [PC_W-1:0] pc_o,
  output logic            idle_o,
  output logic            busy_o,
  output logic            exit_o
);
  localparam int PCH_W  = PC_W - DW;
  localparam int FLG_W  = DW - PCH_W;
  localparam int BS_BIT = SP_W + 1;

  seq_state_t      st_q;
  logic [DW-1:0]   hi_q, lo_q, psw_nxt;
  logic [PC_W-1:0] tgt_q;
  logic            reti_q;
  logic [SP_W-1:0] sp, sp_m1;
  logic            push_go, pop_go;

  function automatic logic [AW-1:0] slot_addr(input logic [SP_W-1:0] s);
    return AW'(STACK_BASE) + (AW'(s) << 1);
  endfunction

  assign sp      = psw_o[SP_W-1:0];
  assign sp_m1   = sp - 1'b1;
  assign idle_o  = (st_q == ST_IDLE);
  assign busy_o  = !idle_o;
  assign exit_o  = (st_q == ST_POP_FIN) && reti_q;
  assign push_go = take_ext_i || take_tmr_i || (idle_o && call_i);
  assign pop_go  = idle_o && !push_go && (ret_i || reti_i);

  always_comb begin
    psw_nxt = psw_o;
    case (st_q)
      ST_IDLE:    if (!push_go && !pop_go && psw_we_i) psw_nxt = psw_d_i;
      ST_PUSH_HI: psw_nxt[SP_W-1:0] = sp + 1'b1;
      ST_POP_FIN: begin
        if (reti_q) psw_nxt[DW-1:DW-FLG_W] = ram_rdata_i[DW-1:DW-FLG_W];
        psw_nxt[SP_W]     = 1'b1;
        psw_nxt[SP_W-1:0] = sp_m1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      psw_o       <= '0;
      bank_base_o <= '0;
      ram_we_o    <= 1'b0;
      ram_addr_o  <= '0;
      ram_wdata_o <= '0;
      pc_load_o   <= 1'b0;
      pc_o        <= '0;
      hi_q        <= '0;
      lo_q        <= '0;
      tgt_q       <= '0;
      reti_q      <= 1'b0;
    end else begin
      psw_o       <= psw_nxt;
      bank_base_o <= psw_nxt[BS_BIT] ? AW'(BANK_BASE) : '0;
      ram_we_o    <= 1'b0;
      pc_load_o   <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (push_go) begin
            ram_we_o    <= 1'b1;
            ram_addr_o  <= slot_addr(sp);
            ram_wdata_o <= pc_i[DW-1:0];
            hi_q        <= {psw_o[DW-1:DW-FLG_W], pc_i[PC_W-1:DW]};
            tgt_q       <= take_ext_i ? PC_W'(EXT_VEC) :
                           take_tmr_i ? PC_W'(TMR_VEC) : call_tgt_i;
            st_q        <= ST_PUSH_HI;
          end else if (pop_go) begin
            ram_addr_o <= slot_addr(sp_m1);
            reti_q     <= reti_i && !ret_i;
            st_q       <= ST_POP_LO;
          end
        end
        ST_PUSH_HI: begin
          ram_we_o    <= 1'b1;
          ram_addr_o  <= ram_addr_o + 1'b1;
          ram_wdata_o <= hi_q;
          pc_o        <= tgt_q;
          pc_load_o   <= 1'b1;
          st_q        <= ST_IDLE;
        end
        ST_POP_LO: begin
          ram_addr_o <= ram_addr_o + 1'b1;
          st_q       <= ST_POP_HI;
        end
        ST_POP_HI: begin
          lo_q <= ram_rdata_i;
          st_q <= ST_POP_FIN;
        end
        ST_POP_FIN: begin
          pc_o      <= {ram_rdata_i[PCH_W-1:0], lo_q};
          pc_load_o <= 1'b1;
          st_q      <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R1
  push_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PUSH_HI) |=> (ram_we_o && ram_addr_o == AW'($past(ram_addr_o) + 1'b1)));

  // R1
  sp_step_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PUSH_HI) |=> (psw_o[SP_W-1:0] == SP_W'($past(psw_o[SP_W-1:0]) + 1'b1)));

  // R3
  pop_mark_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_POP_FIN) |=> (psw_o[SP_W] && pc_load_o));

  // R4
  plain_ret_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_POP_FIN && !reti_q) |=> (psw_o[DW-1:DW-FLG_W] == $past(psw_o[DW-1:DW-FLG_W])));
endmodule

// File: rtl/psw_stack_irq.sv
module psw_stack_irq #(
  parameter int PC_W       = 12,
  parameter int DW         = 8,
  parameter int AW         = 8,
  parameter int SP_W       = 3,
  parameter int STACK_BASE = 8,
  parameter int BANK_BASE  = 24,
  parameter int EXT_VEC    = 3,
  parameter int TMR_VEC    = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            boundary_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic            call_i,
  input  logic [PC_W-1:0] call_tgt_i,
  input  logic            ret_i,
  input  logic            reti_i,
  input  logic            psw_we_i,
  input  logic [DW-1:0]   psw_d_i,
  input  logic            ext_req_i,
  input  logic            ext_en_i,
  input  logic            tmr_ovf_i,
  input  logic            tmr_en_i,
  input  logic [DW-1:0]   ram_rdata_i,
  output logic            ram_we_o,
  output logic [AW-1:0]   ram_addr_o,
  output logic [DW-1:0]   ram_wdata_o,
  output logic [DW-1:0]   psw_o,
  output logic [AW-1:0]   bank_base_o,
  output logic            pc_load_o,
  output logic [PC_W-1:0] pc_o,
  output logic            ext_ack_o,
  output logic            irq_active_o,
  output logic            busy_o
);
  localparam int BS_BIT = SP_W + 1;

  logic take_ext, take_tmr, seq_idle, seq_exit;

  irq_gate u_gate (
    .clk        (clk),
    .rst        (rst),
    .boundary_i (boundary_i),
    .idle_i     (seq_idle),
    .ext_req_i  (ext_req_i),
    .ext_en_i   (ext_en_i),
    .tmr_ovf_i  (tmr_ovf_i),
    .tmr_en_i   (tmr_en_i),
    .exit_i     (seq_exit),
    .take_ext_o (take_ext),
    .take_tmr_o (take_tmr),
    .active_o   (irq_active_o),
    .ack_o      (ext_ack_o)
  );

  frame_seq #(
    .PC_W(PC_W), .DW(DW), .AW(AW), .SP_W(SP_W), .STACK_BASE(STACK_BASE),
    .BANK_BASE(BANK_BASE), .EXT_VEC(EXT_VEC), .TMR_VEC(TMR_VEC)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .take_ext_i  (take_ext),
    .take_tmr_i  (take_tmr),
    .call_i      (call_i),
    .ret_i       (ret_i),
    .reti_i      (reti_i),
    .psw_we_i    (psw_we_i),
    .psw_d_i     (psw_d_i),
    .pc_i        (pc_i),
    .call_tgt_i  (call_tgt_i),
    .ram_rdata_i (ram_rdata_i),
    .ram_we_o    (ram_we_o),
    .ram_addr_o  (ram_addr_o),
    .ram_wdata_o (ram_wdata_o),
    .psw_o       (psw_o),
    .bank_base_o (bank_base_o),
    .pc_load_o   (pc_load_o),
    .pc_o        (pc_o),
    .idle_o      (seq_idle),
    .busy_o      (busy_o),
    .exit_o      (seq_exit)
  );

  // R5
  bank_follow_chk: assert property (@(posedge clk) disable iff (rst)
    bank_base_o == (psw_o[BS_BIT] ? AW'(BANK_BASE) : AW'(0)));
endmodule

// File: tb/psw_stack_irq_bench.sv
module psw_stack_irq_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic boundary_i = 0, call_i = 0, ret_i = 0, reti_i = 0, psw_we_i = 0;
  logic ext_req_i = 0, ext_en_i = 0, tmr_ovf_i = 0, tmr_en_i = 0;
  logic [11:0] pc_i = '0, call_tgt_i = '0;
  logic [7:0] psw_d_i = '0, ram_rdata_i;
  logic ram_we_o, pc_load_o, ext_ack_o, irq_active_o, busy_o;
  logic [7:0] ram_addr_o, ram_wdata_o, psw_o, bank_base_o;
  logic [11:0] pc_o;
  logic [7:0] mem [256];
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  psw_stack_irq u_psw_stack_irq (
    .clk(clk), .rst(rst), .boundary_i(boundary_i), .pc_i(pc_i), .call_i(call_i),
    .call_tgt_i(call_tgt_i), .ret_i(ret_i), .reti_i(reti_i), .psw_we_i(psw_we_i),
    .psw_d_i(psw_d_i), .ext_req_i(ext_req_i), .ext_en_i(ext_en_i),
    .tmr_ovf_i(tmr_ovf_i), .tmr_en_i(tmr_en_i), .ram_rdata_i(ram_rdata_i),
    .ram_we_o(ram_we_o), .ram_addr_o(ram_addr_o), .ram_wdata_o(ram_wdata_o),
    .psw_o(psw_o), .bank_base_o(bank_base_o), .pc_load_o(pc_load_o), .pc_o(pc_o),
    .ext_ack_o(ext_ack_o), .irq_active_o(irq_active_o), .busy_o(busy_o)
  );

  always_ff @(posedge clk) begin
    if (ram_we_o) mem[ram_addr_o] <= ram_wdata_o;
    ram_rdata_i <= mem[ram_addr_o];
  end

  // {flag nibble, return pc, call target}
  localparam logic [27:0] CALL_TAB [8] = '{
    {4'h0, 12'h123, 12'h400}, {4'h1, 12'h456, 12'h511},
    {4'h2, 12'h789, 12'h622}, {4'h4, 12'hABC, 12'h733},
    {4'h8, 12'hDEF, 12'h844}, {4'hF, 12'h001, 12'h955},
    {4'h5, 12'hF00, 12'hA66}, {4'hA, 12'h5A5, 12'hB77}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_strobes();
    boundary_i = 0; call_i = 0; ret_i = 0; reti_i = 0; psw_we_i = 0;
    ext_req_i = 0; tmr_ovf_i = 0;
  endtask

  task automatic wait_load(output int lat, output bit ack);
    @(negedge clk);
    clear_strobes();
    lat = 1;
    ack = ext_ack_o;
    while (!pc_load_o && lat < 12) begin
      @(negedge clk);
      lat++;
      ack |= ext_ack_o;
    end
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic set_psw(input logic [7:0] v);
    @(negedge clk);
    psw_we_i = 1; psw_d_i = v;
    @(negedge clk);
    psw_we_i = 0;
  endtask

  task automatic quiet(input int n, output bit any);
    any = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      clear_strobes();
      any |= pc_load_o | ram_we_o;
    end
  endtask

  task automatic pulse_src(input bit ext, input bit tmr);
    @(negedge clk);
    ext_req_i = ext; tmr_ovf_i = tmr;
    @(negedge clk);
    clear_strobes();
  endtask

  task automatic do_pop(input bit restore, output int lat);
    bit a;
    @(negedge clk);
    if (restore) reti_i = 1; else ret_i = 1;
    wait_load(lat, a);
  endtask

  task automatic do_boundary(output int lat, output bit ack);
    @(negedge clk);
    boundary_i = 1;
    wait_load(lat, ack);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int lat;
    bit ack, any;
    logic [3:0] hi;
    logic [11:0] rpc, tgt;
    logic [7:0] exp_psw;
    for (int k = 0; k < 256; k++) mem[k] = 8'h00;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    chk(psw_o == 8'h00 && bank_base_o == 8'h00, "R10 psw/bank", {psw_o, bank_base_o}, 0);
    chk(!pc_load_o && !ram_we_o && !irq_active_o && !ext_ack_o && !busy_o,
        "R10 strobes", {pc_load_o, ram_we_o, irq_active_o, ext_ack_o, busy_o}, 0);

    // table walk: eight calls fill every slot and wrap sp
    for (int i = 0; i < 8; i++) begin
      {hi, rpc, tgt} = CALL_TAB[i];
      set_psw({hi, 1'b0, 3'(i)});
      // R5 bank select on bit 4
      chk(bank_base_o == (hi[0] ? 8'd24 : 8'd0), "R5 bank after write", bank_base_o, hi[0] ? 24 : 0);
      @(negedge clk);
      call_i = 1; pc_i = rpc; call_tgt_i = tgt;
      wait_load(lat, ack);
      // R11 call target and R1 latency
      chk(lat == 2 && pc_o == tgt, "R11 call target/R1 latency", {lat[15:0], 4'h0, pc_o}, {16'd2, 4'h0, tgt});
      settle();
      // R2 frame packing at R1 slot address
      chk(mem[8 + 2*i] == rpc[7:0], "R2 low byte", mem[8 + 2*i], rpc[7:0]);
      chk(mem[9 + 2*i] == {hi, rpc[11:8]}, "R2 high byte", mem[9 + 2*i], {hi, rpc[11:8]});
      chk(psw_o == {hi, 1'b0, 3'(i + 1)}, "R1 sp increment", psw_o, {hi, 1'b0, 3'(i + 1)});
    end
    chk(psw_o[2:0] == 3'd0, "R1 sp wrap", psw_o[2:0], 0);

    // pulls, alternating restoring and plain
    for (int j = 7; j >= 0; j--) begin
      {hi, rpc, tgt} = CALL_TAB[j];
      set_psw({4'h6, 1'b0, 3'(j + 1)});
      do_pop(j[0], lat);
      exp_psw = j[0] ? {hi, 1'b1, 3'(j)} : {4'h6, 1'b1, 3'(j)};
      chk(lat == 4 && pc_o == rpc, "R3 pull pc/latency", {lat[15:0], 4'h0, pc_o}, {16'd4, 4'h0, rpc});
      chk(psw_o == exp_psw, "R4 flags after pull (R3 bit3)", psw_o, exp_psw);
      chk(bank_base_o == (exp_psw[4] ? 8'd24 : 8'd0), "R5 bank after pull", bank_base_o, exp_psw[4] ? 24 : 0);
    end

    // interrupts
    set_psw(8'h00);
    ext_en_i = 1; tmr_en_i = 1; pc_i = 12'h2AB;
    pulse_src(1, 1);
    quiet(6, any);
    chk(!any, "R9 no take without boundary", any, 0);
    do_boundary(lat, ack);
    chk(lat == 2 && pc_o == 12'h003 && ack, "R7 ext wins vector/ack", {ack, pc_o}, {1'b1, 12'h003});
    settle();
    chk(irq_active_o && mem[8] == 8'hAB && mem[9] == 8'h02, "R7 entry frame/active",
        {irq_active_o, mem[9], mem[8]}, {1'b1, 8'h02, 8'hAB});
    pulse_src(1, 0);
    @(negedge clk); boundary_i = 1;
    quiet(6, any);
    chk(!any && irq_active_o, "R6 no nesting", {any, irq_active_o}, 1);
    do_pop(1, lat);
    settle();
    chk(!irq_active_o && pc_o == 12'h2AB, "R6 reti ends service", {irq_active_o, pc_o}, 12'h2AB);
    do_boundary(lat, ack);
    chk(lat == 2 && pc_o == 12'h003 && ack, "R7 pending kept while in service", {ack, pc_o}, {1'b1, 12'h003});
    settle();
    do_pop(1, lat);
    settle();
    do_boundary(lat, ack);
    chk(lat == 2 && pc_o == 12'h007 && !ack, "R8 timer vector", {ack, pc_o}, 12'h007);
    settle();
    do_pop(0, lat);
    settle();
    chk(irq_active_o, "R6 plain return keeps service", irq_active_o, 1);
    do_pop(1, lat);
    settle();
    chk(!irq_active_o, "R6 reti clears service", irq_active_o, 0);
    @(negedge clk); boundary_i = 1;
    quiet(6, any);
    chk(!any, "R8 overflow latch cleared", any, 0);
    ext_en_i = 0;
    pulse_src(1, 1);
    do_boundary(lat, ack);
    chk(lat == 2 && pc_o == 12'h007 && !ack, "R7 disabled ext loses", {ack, pc_o}, 12'h007);
    settle();
    do_pop(1, lat);
    settle();
    ext_en_i = 1;
    do_boundary(lat, ack);
    chk(lat == 2 && pc_o == 12'h003 && ack, "R7 ext latch survived", {ack, pc_o}, {1'b1, 12'h003});
    settle();
    do_pop(1, lat);
    settle();
    chk(!irq_active_o && !busy_o, "R6 final idle", {irq_active_o, busy_o}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule